// File: doc/BRIEF.md
# Outstanding-Request Handshake Tracker

This block sits beside a downstream slave and keeps count of two kinds of event: how many ready handshakes have been handed to the slave, and how many "get done" completions have come back from it. Each count lives in a small counter that wraps freely. The block never asks which count is larger. It only asks whether the two counts differ. A pending request therefore stays visible even after one of the counters has rolled over.

From the two counts and the slave's active-low status lines, the block drives two outputs. The first is a combinational permit that allows the next slave-ready to be raised. The second is a registered "all complete" flag. The surrounding logic pulses an increment input for each issued ready and for each completion. It holds the pass-through qualifier high to suppress the completion flag.

Top module: `req_track_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, both counters clear to zero and `all_done` is driven to 0. From the first cycle after reset, `slv_en` reads 0 until the counts differ.
- R2: Each clock edge with `issue_pulse` high adds exactly one to the issue count. That count wraps from 15 back to 0 (`CNT_W` = 4). A full lap of 16 issues with no completions returns the two counts to equality.
- R3: Each clock edge with `done_pulse` high adds exactly one to the completion count, which wraps from 15 to 0.
- R4: When `issue_pulse` and `done_pulse` are both high at the same edge, both counts advance in that cycle, and their equality or difference is preserved.
- R5: `slv_en` is high in the same cycle exactly when three conditions hold: the counts differ, `slave_done_n` is 1 and `get_done_n` is 1. In every other case `slv_en` is 0.
- R6: Difference is judged by inequality, never by magnitude. For example, with an issue count of 0 (after a wrap) and a completion count of 15, `slv_en` is 1 when both status lines are high.
- R7: `all_done` goes to 1 one clock after an edge at which three conditions hold: the counts are equal, `slave_done_n` is 0 and `hold_q` is 0.
- R8: `all_done` goes to 0 one clock after an edge at which any of the following is true: the counts differ, `slave_done_n` is 1, or `hold_q` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| issue_pulse | input | 1 | One-cycle pulse per slave-ready issued |
| done_pulse | input | 1 | One-cycle pulse per get-done completion |
| slave_done_n | input | 1 | Slave done status, active low |
| get_done_n | input | 1 | Get-done status, active low |
| hold_q | input | 1 | Pass-through qualifier; high suppresses the completion flag |
| slv_en | output | 1 | Permit to assert the next slave-ready (combinational) |
| all_done | output | 1 | Registered flag: all issued requests are complete |

## Verification
The bound assertions check four things on every cycle. Each counter moves by exactly one step or holds. The permit never rises while a status line is asserted or while the counts match. The completion flag follows its qualifying condition one edge later, in both directions. Only the bench's scenarios can show the behaviour that depends on wrap-around. These are a full 16-step lap that restores equality, and an issue count of 0 against a completion count of 15 that must still enable the slave. The scenarios also show that lock-step increments keep the flag stable, and that reset overrides pulses that arrive while it is held.

// File: rtl/req_track_pkg.sv
// Package: shared constants for the outstanding-request tracker.
// Assumes: counters are indexed by cnt_sel_e when built as an array.
package req_track_pkg;
    localparam int unsigned DEF_CNT_W = 4;
    localparam int unsigned NUM_CNT   = 2;

    typedef enum int unsigned {
        CNT_ISSUE = 0,
        CNT_DONE  = 1
    } cnt_sel_e;
endpackage

// File: rtl/wrap_cnt.sv
// Module: free-running wrap-around event counter.
// Adds one on each cycle that step is high and wraps silently on overflow.
// Assumes: synchronous active-low reset; step is already a clean one-cycle pulse.
module wrap_cnt #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    output logic [W-1:0] value
);
    // Count qualifying steps; overflow wraps by modular arithmetic.
    always_ff @(posedge clk) begin
        if (!rst_n)
            value <= '0;
        else if (step)
            value <= value + W'(1);
    end
endmodule

// File: rtl/slv_gate.sv
// Module: combinational permit for the next slave-ready.
// The permit is granted only while the counts differ and both status lines are idle (high).
// Assumes: counts wrap, so only inequality is meaningful.
module slv_gate #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] iss_cnt,
    input  logic [W-1:0] cmp_cnt,
    input  logic         slave_done_n,
    input  logic         get_done_n,
    output logic         en
);
    logic counts_differ;

    // Wrap-safe comparison followed by qualification with the status lines.
    always_comb begin
        counts_differ = (iss_cnt != cmp_cnt);
        en = counts_differ && slave_done_n && get_done_n;
    end
endmodule

// File: rtl/done_flag_reg.sv
// Module: registered "all requests complete" flag.
// Samples equality of the counts, qualified by slave-done active and hold low.
// Assumes: synchronous active-low reset; the flag is cleared whenever the condition fails.
module done_flag_reg #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] iss_cnt,
    input  logic [W-1:0] cmp_cnt,
    input  logic         slave_done_n,
    input  logic         hold_q,
    output logic         flag
);
    logic cond;

    // Condition for completion, evaluated on the present counts.
    always_comb cond = (iss_cnt == cmp_cnt) && !slave_done_n && !hold_q;

    // Register the condition so the flag is seen one clock later.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag <= 1'b0;
        else
            flag <= cond;
    end
endmodule

// File: rtl/req_track_ctrl.sv
// Module: outstanding-request handshake tracker (top).
// Counts issued slave-ready handshakes and returned get-done completions in two
// wrapping counters. It drives a combinational slave-ready permit and a registered
// completion flag.
// Assumes: increment inputs are single-cycle pulses synchronous to clk.
module req_track_ctrl
    import req_track_pkg::*;
#(
    parameter int unsigned CNT_W = DEF_CNT_W
) (
    input  logic clk,
    input  logic rst_n,
    input  logic issue_pulse,
    input  logic done_pulse,
    input  logic slave_done_n,
    input  logic get_done_n,
    input  logic hold_q,
    output logic slv_en,
    output logic all_done
);
    logic [NUM_CNT-1:0] step_v;
    logic [CNT_W-1:0]   cnt_q [NUM_CNT];
    logic [CNT_W-1:0]   iss_cnt;
    logic [CNT_W-1:0]   cmp_cnt;

    // Gather the increment pulses in counter-index order.
    always_comb begin
        step_v[CNT_ISSUE] = issue_pulse;
        step_v[CNT_DONE]  = done_pulse;
    end

    // One wrapping counter per tracked event kind.
    for (genvar gi = 0; gi < NUM_CNT; gi++) begin : g_cnt
        wrap_cnt #(.W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .step  (step_v[gi]),
            .value (cnt_q[gi])
        );
    end

    // Name the two counts for the downstream logic.
    always_comb begin
        iss_cnt = cnt_q[CNT_ISSUE];
        cmp_cnt = cnt_q[CNT_DONE];
    end

    slv_gate #(.W(CNT_W)) u_gate (
        .iss_cnt      (iss_cnt),
        .cmp_cnt      (cmp_cnt),
        .slave_done_n (slave_done_n),
        .get_done_n   (get_done_n),
        .en           (slv_en)
    );

    done_flag_reg #(.W(CNT_W)) u_flag (
        .clk          (clk),
        .rst_n        (rst_n),
        .iss_cnt      (iss_cnt),
        .cmp_cnt      (cmp_cnt),
        .slave_done_n (slave_done_n),
        .hold_q       (hold_q),
        .flag         (all_done)
    );
endmodule

// File: rtl/req_track_ctrl_chk.sv
// Module: assertion checker for req_track_ctrl, attached by bind.
// Assumes: it observes the internal counts through the bind connection.
module req_track_ctrl_chk #(
    parameter int unsigned CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             issue_pulse,
    input logic             done_pulse,
    input logic             slave_done_n,
    input logic             get_done_n,
    input logic             hold_q,
    input logic             slv_en,
    input logic             all_done,
    input logic [CNT_W-1:0] iss_cnt,
    input logic [CNT_W-1:0] cmp_cnt
);
    p_iss_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        issue_pulse |=> iss_cnt == CNT_W'($past(iss_cnt) + 1'b1));

    p_iss_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_pulse |=> $stable(iss_cnt));

    p_cmp_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> cmp_cnt == CNT_W'($past(cmp_cnt) + 1'b1));

    p_cmp_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !done_pulse |=> $stable(cmp_cnt));

    p_en_qual_r5: assert property (@(posedge clk) disable iff (!rst_n)
        slv_en |-> (slave_done_n && get_done_n));

    p_en_differ_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_cnt == cmp_cnt) |-> !slv_en);

    p_flag_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((iss_cnt == cmp_cnt) && !slave_done_n && !hold_q) |=> all_done);

    p_flag_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((iss_cnt != cmp_cnt) || slave_done_n || hold_q) |=> !all_done);
endmodule

bind req_track_ctrl req_track_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .issue_pulse  (issue_pulse),
    .done_pulse   (done_pulse),
    .slave_done_n (slave_done_n),
    .get_done_n   (get_done_n),
    .hold_q       (hold_q),
    .slv_en       (slv_en),
    .all_done     (all_done),
    .iss_cnt      (iss_cnt),
    .cmp_cnt      (cmp_cnt)
);

// File: tb/req_track_ctrl_tb_top.sv
`timescale 1ns/1ps
// Bench: a behavioural reference model compared on every clock.
module req_track_ctrl_tb_top;
    localparam int MOD = 16;

    logic clk = 1'b0;
    logic rst_n, issue_pulse, done_pulse, slave_done_n, get_done_n, hold_q;
    logic slv_en, all_done;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    int ref_iss = 0;
    int ref_cmp = 0;
    bit ref_flag = 0;

    always #2.5 clk = ~clk;

    req_track_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .issue_pulse(issue_pulse), .done_pulse(done_pulse),
        .slave_done_n(slave_done_n), .get_done_n(get_done_n), .hold_q(hold_q),
        .slv_en(slv_en), .all_done(all_done)
    );

    task automatic check(input string tag, input logic act, input bit exp, input string what);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%b expected=%b at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Drive one cycle, compare outputs mid-cycle, then advance the model at the edge.
    task automatic step(input string tag, input bit rst, input bit ip, input bit dp,
                        input bit sdn, input bit gdn, input bit hq);
        bit exp_en;
        rst_n = rst; issue_pulse = ip; done_pulse = dp;
        slave_done_n = sdn; get_done_n = gdn; hold_q = hq;
        #1;
        exp_en = (ref_iss != ref_cmp) && sdn && gdn;
        if (!first_cycle) begin
            check(tag, slv_en, exp_en, "slv_en");
            check(tag, all_done, ref_flag, "all_done");
        end
        @(posedge clk);
        if (!rst) begin
            ref_iss = 0; ref_cmp = 0; ref_flag = 0;
        end else begin
            ref_flag = (ref_iss == ref_cmp) && !sdn && !hq;
            if (ip) ref_iss = (ref_iss + 1) % MOD;
            if (dp) ref_cmp = (ref_cmp + 1) % MOD;
        end
        first_cycle = 0;
        @(negedge clk);
    endtask

    bit first_cycle = 1;

    initial begin
        #1000000;
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog (all R): actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R1: reset wins over pulses presented during it.
        for (int i = 0; i < 3; i++) step("R1", 0, 1, 1, 0, 1, 0);
        check("R1", all_done, 1'b0, "all_done after reset");
        check("R1", slv_en, 1'b0, "slv_en after reset");
        // R2/R5: issue three, permit rises with idle status lines.
        for (int i = 0; i < 3; i++) step("R2", 1, 1, 0, 1, 1, 0);
        step("R5", 1, 0, 0, 1, 1, 0);
        step("R5", 1, 0, 0, 1, 0, 0);   // get-done active blocks permit
        step("R8", 1, 0, 0, 0, 1, 0);   // counts differ: flag stays low
        step("R8", 1, 0, 0, 0, 1, 0);
        // R3: complete three, then R7 flag rises one clock later.
        for (int i = 0; i < 3; i++) step("R3", 1, 0, 1, 1, 1, 0);
        step("R7", 1, 0, 0, 0, 1, 0);
        step("R7", 1, 0, 0, 0, 1, 0);
        step("R8", 1, 0, 0, 0, 1, 1);   // hold suppresses
        step("R8", 1, 0, 0, 0, 1, 0);
        step("R8", 1, 0, 0, 1, 1, 0);   // slave-done idle clears
        step("R8", 1, 0, 0, 0, 1, 0);
        // R4: lock-step pulses keep equality and the flag high.
        for (int i = 0; i < 20; i++) step("R4", 1, 1, 1, 0, 1, 0);
        step("R4", 1, 0, 0, 1, 1, 0);
        // R2 wrap: sixteen issues return to equality.
        for (int i = 0; i < 16; i++) step("R2", 1, 1, 0, 1, 1, 0);
        step("R2", 1, 0, 0, 1, 1, 0);
        step("R2", 1, 0, 0, 0, 1, 0);
        step("R2", 1, 0, 0, 0, 1, 0);
        // R6: completion 15 vs issue wrapped to 0.
        for (int i = 0; i < 3; i++) step("R1", 0, 0, 0, 1, 1, 0);
        for (int i = 0; i < 15; i++) step("R6", 1, 0, 1, 1, 1, 0);
        step("R6", 1, 0, 0, 1, 1, 0);
        for (int i = 0; i < 16; i++) step("R6", 1, 1, 0, 1, 1, 0);
        step("R6", 1, 0, 0, 1, 1, 0);
        // Mixed patterns against the model (R5, R7).
        for (int i = 0; i < 400; i++) begin
            int r;
            r = $urandom;
            step("R5_R7", (r % 50) != 0, r[4], r[5], r[6] | r[7], r[8] | r[9], r[10] & r[11]);
        end
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule